// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host's write strobe and two flash arrays and reads every qualified write cycle as one byte of a command sequence rather than as a store. A sequence starts with two unlock writes, carries a command byte, and for some commands one or more further bytes. When the last byte of a correct sequence arrives, the block reports the decoded operation for one clock together with the bank it is aimed at. A wrong byte, a wrong address, a switch of bank part way through, or too long a pause between writes abandons the sequence and returns the bank to read-array mode.

Two groups of sector-select lines steer each write: eight lines belong to the primary bank and four to the secondary bank. Each bank keeps its own read mode (array, status, identifier or protection status) and its own bypass flag; with bypass on, command bytes are taken without the unlock pair. A supply-lockout input blocks all writes. Only the low 12 address bits take part in matching, so the upper address bits are not brought into the block. Array programming, erase timing and the voltage detector live elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, cmd_valid is 0, cmd_op is 0, both banks are in array mode (mode code 0) and bypass is off in both banks.
- R2: A sequence starts with data AAh at address AAAh then data 55h at address 554h (low 12 bits), followed by the command byte at address AAAh; the decoded operation appears on cmd_valid/cmd_op/cmd_bank for exactly the one clock after the edge that accepted the final write, with cmd_op 0 whenever cmd_valid is 0.
- R3: Command bytes and the operation codes reported: A0h program (1), 80h erase setup, F0h reset (6), B0h suspend (4), 30h resume (5), 90h identifier read (7), C0h protection-status read (8), 20h bypass enter (9); any other command byte abandons the sequence.
- R4: Program needs one further write of any data at any address after A0h (op 1). Erase needs, after 80h, a second unlock pair and a confirm byte: 10h at AAAh reports chip erase (op 2), 30h at any address reports sector erase (op 3).
- R5: An invalid data byte or address within a sequence, or a write to the other bank mid-sequence, ends the sequence with no report and sets the sequence's bank to array mode; an unrecognised write from idle sets the written bank to array mode.
- R6: With timeout limit L, up to L idle clocks between two sequence writes are accepted; after L+1 idle clocks the sequence is abandoned and its bank returns to array mode. No counting happens while idle.
- R7: A write targets the primary bank (cmd_bank 0) if any of its 8 select lines is high, else the secondary bank (cmd_bank 1) if any of its 4 lines is high; primary wins when both groups are high. A write with no select line high is ignored and leaves a sequence in progress intact.
- R8: The identifier read is accepted only by the primary bank; on the secondary bank the 90h command abandons the sequence.
- R9: Writes while lockout is high are ignored and do not disturb a sequence in progress.
- R10: Bypass enter sets the bank's bypass flag; in bypass, a command byte at AAAh is taken without an unlock pair, erase needs only 80h then the confirm byte, and F0h at AAAh reports bypass exit (op 10) and clears the flag.
- R11: After a report, the bank's mode code is 1 (status) for program, chip erase, sector erase and resume; 2 for identifier read; 3 for protection-status read; 0 (array) for reset, suspend, bypass enter and bypass exit.
- R12: From idle, without unlock, B0h reports suspend, 30h reports resume and F0h reports reset, at any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 12 | Low address bits of the write |
| wr_data | input | 8 | Write data byte |
| sel_pri | input | 8 | Primary bank sector selects |
| sel_sec | input | 4 | Secondary bank sector selects |
| lockout | input | 1 | Supply lockout; blocks writes while high |
| tmo_limit | input | 16 | Allowed idle clocks between sequence writes |
| cmd_valid | output | 1 | One-clock pulse for a decoded operation |
| cmd_op | output | 4 | Operation code (R3, R4, R10) |
| cmd_bank | output | 1 | 0 primary, 1 secondary |
| mode_pri | output | 2 | Primary bank read mode |
| mode_sec | output | 2 | Secondary bank read mode |

## Verification
Every result is due one clock after the edge that takes the final write: the operation pulse and the bank's new mode appear together, and an abort caused by a bad byte shows in the mode at the same point. A timeout abort shows after the (L+1)-th idle edge following the last accepted write. The bench drives each write for one cycle from the falling edge and reads the outputs at the next falling edge, so each check sits half a clock after the edge that should have changed them, and timeout checks count idle falling edges from there.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and types for the flash command sequence decoder.
// Assumes 8-bit command bytes and 12 matched address bits.
package flash_cmd_pkg;
    localparam int MATCH_W = 12;

    localparam logic [MATCH_W-1:0] ADDR_KEY_A = 12'hAAA;
    localparam logic [MATCH_W-1:0] ADDR_KEY_B = 12'h554;

    localparam logic [7:0] D_KEY_A     = 8'hAA;
    localparam logic [7:0] D_KEY_B     = 8'h55;
    localparam logic [7:0] D_PROGRAM   = 8'hA0;
    localparam logic [7:0] D_ERASE_SET = 8'h80;
    localparam logic [7:0] D_CHIP      = 8'h10;
    localparam logic [7:0] D_SECTOR    = 8'h30;
    localparam logic [7:0] D_RESUME    = 8'h30;
    localparam logic [7:0] D_SUSPEND   = 8'hB0;
    localparam logic [7:0] D_RESET     = 8'hF0;
    localparam logic [7:0] D_IDENT     = 8'h90;
    localparam logic [7:0] D_PROTECT   = 8'hC0;
    localparam logic [7:0] D_BYPASS    = 8'h20;

    localparam logic BANK_PRI = 1'b0;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_PROGRAM    = 4'd1,
        OP_ERASE_CHIP = 4'd2,
        OP_ERASE_SECT = 4'd3,
        OP_SUSPEND    = 4'd4,
        OP_RESUME     = 4'd5,
        OP_RESET      = 4'd6,
        OP_READ_ID    = 4'd7,
        OP_READ_PROT  = 4'd8,
        OP_BYPASS_ON  = 4'd9,
        OP_BYPASS_OFF = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        MODE_ARRAY   = 2'd0,
        MODE_STATUS  = 2'd1,
        MODE_IDENT   = 2'd2,
        MODE_PROTECT = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ERS1, ST_ERS2, ST_ERS3
    } state_e;

    typedef struct packed {
        state_e st;
        logic   fire;
        op_e    op;
        logic   abort;
    } step_t;

    // Read mode a bank takes after reporting an operation.
    function automatic mode_e mode_after(op_e op);
        case (op)
            OP_PROGRAM, OP_ERASE_CHIP, OP_ERASE_SECT, OP_RESUME: return MODE_STATUS;
            OP_READ_ID:   return MODE_IDENT;
            OP_READ_PROT: return MODE_PROTECT;
            default:      return MODE_ARRAY;
        endcase
    endfunction
endpackage

// File: rtl/flash_bank_sel.sv
// Bank steering: turns the two sector-select groups into a hit flag and a
// bank index. Assumes primary has priority when both groups are active.
module flash_bank_sel #(
    parameter int N_PRI = 8,
    parameter int N_SEC = 4
) (
    input  logic [N_PRI-1:0] sel_pri,
    input  logic [N_SEC-1:0] sel_sec,
    output logic             hit,
    output logic             bank
);
    logic any_pri;
    logic any_sec;

    // Reduce each group and pick the bank, primary first.
    always_comb begin
        any_pri = |sel_pri;
        any_sec = |sel_sec;
        hit     = any_pri | any_sec;
        bank    = any_pri ? 1'b0 : 1'b1;
    end
endmodule

// File: rtl/flash_seq_timer.sv
// Inter-byte timeout counter. Counts idle clocks while a sequence is open,
// clears on each accepted write and stays at zero when no sequence is open.
module flash_seq_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             wr_ok,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] cnt_q;

    // Idle-clock counter with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || wr_ok) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry once the allowed idle clocks have all been used.
    always_comb expire = busy && (cnt_q >= limit);
endmodule

// File: rtl/flash_seq_fsm.sv
// Sequence decoder: walks unlock, command and confirm bytes for one bank at
// a time. Emits combinational step events (used by the bank state) and
// registers the one-clock operation report. Assumes wr_ok is already
// qualified by lockout and bank selects.
module flash_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ok,
    input  logic               wr_bank,
    input  logic [MATCH_W-1:0] addr_lo,
    input  logic [7:0]         wr_data,
    input  logic               tmo_expire,
    input  logic [1:0]         byp_vec,
    output logic               busy,
    output logic               evt_fire,
    output op_e                evt_op,
    output logic               evt_abort,
    output logic               evt_bank,
    output logic               cmd_valid,
    output op_e                cmd_op,
    output logic               cmd_bank
);
    state_e st_q;
    logic   bank_q;
    step_t  step;
    logic   bank_d;
    logic   at_a;
    logic   at_b;
    logic   same;

    // Decode a command byte taken after unlock or in bypass.
    function automatic step_t decode_cmd(logic [7:0] d, logic bank, logic byp);
        step_t s;
        s = '{st: ST_IDLE, fire: 1'b0, op: OP_NONE, abort: 1'b0};
        case (d)
            D_PROGRAM:   s.st = ST_PROG;
            D_ERASE_SET: s.st = byp ? ST_ERS3 : ST_ERS1;
            D_RESET:     begin s.fire = 1'b1; s.op = byp ? OP_BYPASS_OFF : OP_RESET; end
            D_IDENT:     begin
                if (bank == BANK_PRI) begin s.fire = 1'b1; s.op = OP_READ_ID; end
                else s.abort = 1'b1;
            end
            D_PROTECT:   begin s.fire = 1'b1; s.op = OP_READ_PROT; end
            D_BYPASS:    begin s.fire = 1'b1; s.op = OP_BYPASS_ON; end
            D_SUSPEND:   begin s.fire = 1'b1; s.op = OP_SUSPEND; end
            D_RESUME:    begin s.fire = 1'b1; s.op = OP_RESUME; end
            default:     s.abort = 1'b1;
        endcase
        return s;
    endfunction

    // Next-step decode for the current write or a timeout.
    always_comb begin
        at_a   = (addr_lo == ADDR_KEY_A);
        at_b   = (addr_lo == ADDR_KEY_B);
        same   = (wr_bank == bank_q);
        bank_d = bank_q;
        step   = '{st: st_q, fire: 1'b0, op: OP_NONE, abort: 1'b0};
        if (wr_ok) begin
            case (st_q)
                ST_IDLE: begin
                    bank_d = wr_bank;
                    if (wr_data == D_KEY_A && at_a)      step.st = ST_KEY1;
                    else if (byp_vec[wr_bank] && at_a)   step = decode_cmd(wr_data, wr_bank, 1'b1);
                    else if (wr_data == D_SUSPEND)       begin step.fire = 1'b1; step.op = OP_SUSPEND; end
                    else if (wr_data == D_RESUME)        begin step.fire = 1'b1; step.op = OP_RESUME; end
                    else if (wr_data == D_RESET)         begin step.fire = 1'b1; step.op = OP_RESET; end
                    else                                 step.abort = 1'b1;
                end
                ST_KEY1: begin
                    if (same && wr_data == D_KEY_B && at_b) step.st = ST_KEY2;
                    else step.abort = 1'b1;
                end
                ST_KEY2: begin
                    if (same && at_a) step = decode_cmd(wr_data, bank_q, byp_vec[bank_q]);
                    else step.abort = 1'b1;
                end
                ST_PROG: begin
                    if (same) begin step.fire = 1'b1; step.op = OP_PROGRAM; end
                    else step.abort = 1'b1;
                end
                ST_ERS1: begin
                    if (same && wr_data == D_KEY_A && at_a) step.st = ST_ERS2;
                    else step.abort = 1'b1;
                end
                ST_ERS2: begin
                    if (same && wr_data == D_KEY_B && at_b) step.st = ST_ERS3;
                    else step.abort = 1'b1;
                end
                ST_ERS3: begin
                    if (same && wr_data == D_CHIP && at_a) begin
                        step.fire = 1'b1; step.op = OP_ERASE_CHIP;
                    end else if (same && wr_data == D_SECTOR) begin
                        step.fire = 1'b1; step.op = OP_ERASE_SECT;
                    end else begin
                        step.abort = 1'b1;
                    end
                end
                default: step.abort = 1'b1;
            endcase
        end else if (st_q != ST_IDLE && tmo_expire) begin
            step.abort = 1'b1;
        end
        if (step.fire || step.abort) step.st = ST_IDLE;
    end

    // Event outputs seen by the per-bank state.
    always_comb begin
        busy      = (st_q != ST_IDLE);
        evt_fire  = step.fire;
        evt_op    = step.op;
        evt_abort = step.abort;
        evt_bank  = bank_d;
    end

    // Sequence state and bank register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            bank_q <= 1'b0;
        end else begin
            st_q   <= step.st;
            bank_q <= bank_d;
        end
    end

    // One-clock operation report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_op    <= OP_NONE;
            cmd_bank  <= 1'b0;
        end else begin
            cmd_valid <= step.fire;
            cmd_op    <= step.fire ? step.op : OP_NONE;
            if (step.fire) cmd_bank <= bank_d;
        end
    end
endmodule

// File: rtl/flash_bank_state.sv
// Per-bank read mode and bypass flag. Updates on the same edge as the
// operation report, from the decoder's step events.
module flash_bank_state
    import flash_cmd_pkg::*;
#(
    parameter bit BANK_ID = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  evt_fire,
    input  op_e   evt_op,
    input  logic  evt_abort,
    input  logic  evt_bank,
    output mode_e mode,
    output logic  bypass
);
    logic mine;

    // Event is aimed at this bank.
    always_comb mine = (evt_bank == BANK_ID);

    // Mode and bypass update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_ARRAY;
            bypass <= 1'b0;
        end else if (evt_fire && mine) begin
            mode <= mode_after(evt_op);
            if (evt_op == OP_BYPASS_ON)       bypass <= 1'b1;
            else if (evt_op == OP_BYPASS_OFF) bypass <= 1'b0;
        end else if (evt_abort && mine) begin
            mode <= MODE_ARRAY;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command sequence decoder. Qualifies writes by lockout
// and bank selects, runs the sequence decoder and timeout, and keeps one
// mode/bypass state per bank. Assumes a one-cycle write strobe.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int N_PRI = 8,
    parameter int N_SEC = 4,
    parameter int TMO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [MATCH_W-1:0] wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [N_PRI-1:0]   sel_pri,
    input  logic [N_SEC-1:0]   sel_sec,
    input  logic               lockout,
    input  logic [TMO_W-1:0]   tmo_limit,
    output logic               cmd_valid,
    output logic [3:0]         cmd_op,
    output logic               cmd_bank,
    output logic [1:0]         mode_pri,
    output logic [1:0]         mode_sec
);
    localparam int N_BANKS = 2;

    logic  hit;
    logic  wr_bank;
    logic  wr_ok;
    logic  busy;
    logic  expire;
    logic  evt_fire;
    op_e   evt_op;
    logic  evt_abort;
    logic  evt_bank;
    op_e   op_q;
    logic [N_BANKS-1:0] byp_vec;
    mode_e mode_vec [N_BANKS];

    flash_bank_sel #(.N_PRI(N_PRI), .N_SEC(N_SEC)) u_sel (
        .sel_pri (sel_pri),
        .sel_sec (sel_sec),
        .hit     (hit),
        .bank    (wr_bank)
    );

    // A write counts only when selected and not locked out.
    always_comb wr_ok = wr_stb && !lockout && hit;

    flash_seq_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .wr_ok  (wr_ok),
        .limit  (tmo_limit),
        .expire (expire)
    );

    flash_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .wr_bank    (wr_bank),
        .addr_lo    (wr_addr),
        .wr_data    (wr_data),
        .tmo_expire (expire),
        .byp_vec    (byp_vec),
        .busy       (busy),
        .evt_fire   (evt_fire),
        .evt_op     (evt_op),
        .evt_abort  (evt_abort),
        .evt_bank   (evt_bank),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op_q),
        .cmd_bank   (cmd_bank)
    );

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        flash_bank_state #(.BANK_ID(g != 0)) u_state (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_fire  (evt_fire),
            .evt_op    (evt_op),
            .evt_abort (evt_abort),
            .evt_bank  (evt_bank),
            .mode      (mode_vec[g]),
            .bypass    (byp_vec[g])
        );
    end

    // Drive the plain-typed output ports.
    always_comb begin
        cmd_op   = op_q;
        mode_pri = mode_vec[0];
        mode_sec = mode_vec[1];
    end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
// Assertion checker for flash_cmd_decoder, attached by bind below.
module flash_cmd_decoder_chk #(
    parameter int N_PRI = 8,
    parameter int N_SEC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stb,
    input logic             lockout,
    input logic [N_PRI-1:0] sel_pri,
    input logic [N_SEC-1:0] sel_sec,
    input logic             cmd_valid,
    input logic [3:0]       cmd_op,
    input logic             cmd_bank,
    input logic [1:0]       mode_pri,
    input logic [1:0]       mode_sec
);
    // R2: a report only follows a strobed write
    p_report_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_stb));

    // R2: op code is zero when no report
    p_op_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> cmd_op == 4'd0);

    // R3: reported codes are in range
    p_op_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op != 4'd0 && cmd_op <= 4'd10));

    // R9: no report from a locked-out write
    p_lockout_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !$past(lockout));

    // R7: reported bank follows the selects of the final write
    p_bank_steer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_bank == !$past(|sel_pri)) && $past((|sel_pri) || (|sel_sec)));

    // R8: identifier read only on the primary bank, which enters ident mode
    p_ident_primary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd7) |-> (cmd_bank == 1'b0 && mode_pri == 2'd2));

    // R11: protection read on the secondary bank sets its mode
    p_prot_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd8 && cmd_bank) |-> mode_sec == 2'd3);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.N_PRI(N_PRI), .N_SEC(N_SEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .lockout   (lockout),
    .sel_pri   (sel_pri),
    .sel_sec   (sel_sec),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .mode_pri  (mode_pri),
    .mode_sec  (mode_sec)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    localparam int E_PROGRAM = 1, E_CHIP = 2, E_SECT = 3, E_SUSPEND = 4, E_RESUME = 5,
                   E_RESET = 6, E_IDENT = 7, E_PROT = 8, E_BYP_ON = 9, E_BYP_OFF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  sel_pri = '0;
    logic [3:0]  sel_sec = '0;
    logic        lockout = 1'b0;
    logic [15:0] tmo_limit = 16'd8;
    logic        cmd_valid;
    logic [3:0]  cmd_op;
    logic        cmd_bank;
    logic [1:0]  mode_pri;
    logic [1:0]  mode_sec;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic       s_valid;
    logic [3:0] s_op;
    logic       s_bank;

    always #4 clk = ~clk;

    flash_cmd_decoder u_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_pri(sel_pri), .sel_sec(sel_sec), .lockout(lockout), .tmo_limit(tmo_limit),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .mode_pri(mode_pri), .mode_sec(mode_sec)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_mode(input int op);
        case (op)
            E_PROGRAM, E_CHIP, E_SECT, E_RESUME: return 1;
            E_IDENT: return 2;
            E_PROT:  return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int code_op(input logic [7:0] code, input logic [7:0] conf);
        case (code)
            8'hA0: return E_PROGRAM;
            8'h80: return (conf == 8'h10) ? E_CHIP : E_SECT;
            8'hF0: return E_RESET;
            8'hB0: return E_SUSPEND;
            8'h30: return E_RESUME;
            8'h90: return E_IDENT;
            8'hC0: return E_PROT;
            default: return E_BYP_ON;
        endcase
    endfunction

    function automatic logic [7:0] rnd_pri();
        logic [7:0] v = 8'($urandom);
        return (v == 8'h00) ? 8'h01 : v;
    endfunction

    function automatic logic [3:0] rnd_sec();
        logic [3:0] v = 4'($urandom);
        return (v == 4'h0) ? 4'h8 : v;
    endfunction

    // One write cycle; outputs captured half a clock after the taking edge.
    task automatic wr_raw(input logic [11:0] a, input logic [7:0] d,
                          input logic [7:0] p, input logic [3:0] s, input bit lo);
        wr_addr = a; wr_data = d; sel_pri = p; sel_sec = s; lockout = lo; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; sel_pri = '0; sel_sec = '0; lockout = 1'b0;
        s_valid = cmd_valid; s_op = cmd_op; s_bank = cmd_bank;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input bit bank);
        if (bank) wr_raw(a, d, 8'h00, rnd_sec(), 1'b0);
        else      wr_raw(a, d, rnd_pri(), 4'h0, 1'b0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int bank_mode(input bit bank);
        return bank ? int'(mode_sec) : int'(mode_pri);
    endfunction

    task automatic expect_none(input string req);
        chk(s_valid == 1'b0, req, int'(s_valid), 0);
    endtask

    task automatic expect_cmd(input string req, input int op, input bit bank);
        chk(s_valid == 1'b1, req, int'(s_valid), 1);
        chk(int'(s_op) == op, req, int'(s_op), op);
        chk(s_bank == bank, req, int'(s_bank), int'(bank));
        chk(bank_mode(bank) == exp_mode(op), {req, " R11 mode"}, bank_mode(bank), exp_mode(op));
    endtask

    task automatic unlock(input bit bank, input int gap);
        wr(12'hAAA, 8'hAA, bank); expect_none("R2 first key");  idle(gap);
        wr(12'h554, 8'h55, bank); expect_none("R2 second key"); idle(gap);
    endtask

    task automatic run_cmd(input bit bank, input logic [7:0] code, input bit byp,
                           input int gap, input logic [7:0] conf, input string req);
        if (!byp) unlock(bank, gap);
        wr(12'hAAA, code, bank);
        if (code == 8'hA0) begin
            expect_none(req); idle(gap);
            wr(12'($urandom), 8'($urandom), bank);
        end else if (code == 8'h80) begin
            expect_none(req); idle(gap);
            if (!byp) unlock(bank, gap);
            wr((conf == 8'h10) ? 12'hAAA : 12'($urandom), conf, bank);
        end
        expect_cmd(req, code_op(code, conf), bank);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cmd_valid == 1'b0, "R1 valid", int'(cmd_valid), 0);
        chk(cmd_op == 4'd0, "R1 op", int'(cmd_op), 0);
        chk(mode_pri == 2'd0, "R1 mode_pri", int'(mode_pri), 0);
        chk(mode_sec == 2'd0, "R1 mode_sec", int'(mode_sec), 0);

        // R2 R4: program and erases on both banks
        run_cmd(1'b0, 8'hA0, 1'b0, 0, 8'h00, "R2 R4 program pri");
        run_cmd(1'b1, 8'h80, 1'b0, 1, 8'h10, "R4 chip erase sec");
        run_cmd(1'b0, 8'h80, 1'b0, 0, 8'h30, "R4 sector erase pri");
        idle(1);
        chk(s_valid == 1'b1 && cmd_valid == 1'b0, "R2 one-clock pulse", int'(cmd_valid), 0);

        // R8 R3: identifier read on primary, refused on secondary
        run_cmd(1'b0, 8'h90, 1'b0, 0, 8'h00, "R8 R3 ident pri");
        run_cmd(1'b1, 8'hC0, 1'b0, 0, 8'h00, "R3 prot sec");
        unlock(1'b1, 0);
        wr(12'hAAA, 8'h90, 1'b1);
        expect_none("R8 ident sec");
        chk(mode_sec == 2'd0, "R8 R5 sec to array", int'(mode_sec), 0);

        // R5: wrong address in second key
        run_cmd(1'b0, 8'hC0, 1'b0, 0, 8'h00, "R5 setup");
        wr(12'hAAA, 8'hAA, 1'b0);
        wr(12'h555, 8'h55, 1'b0);
        expect_none("R5 bad key addr");
        chk(mode_pri == 2'd0, "R5 pri to array", int'(mode_pri), 0);
        wr(12'hAAA, 8'hA0, 1'b0); expect_none("R5 no resume of sequence");
        wr(12'h010, 8'h3C, 1'b0); expect_none("R5 no program");
        // R5: bank switch mid-sequence
        run_cmd(1'b1, 8'hA0, 1'b0, 0, 8'h00, "R5 setup sec");
        wr(12'hAAA, 8'hAA, 1'b1);
        wr(12'h554, 8'h55, 1'b0);
        expect_none("R5 bank switch");
        chk(mode_sec == 2'd0, "R5 sec to array after switch", int'(mode_sec), 0);

        // R6: timeout boundary
        tmo_limit = 16'd4;
        run_cmd(1'b0, 8'hA0, 1'b0, 4, 8'h00, "R6 gap equal to limit");
        run_cmd(1'b0, 8'hC0, 1'b0, 0, 8'h00, "R6 setup");
        wr(12'hAAA, 8'hAA, 1'b0);
        idle(5);
        chk(mode_pri == 2'd0, "R6 timeout to array", int'(mode_pri), 0);
        wr(12'h554, 8'h55, 1'b0); expect_none("R6 stale key");
        wr(12'hAAA, 8'hC0, 1'b0); expect_none("R6 stale command");
        tmo_limit = 16'd8;

        // R7: unselected write ignored mid-sequence; primary priority
        wr(12'hAAA, 8'hAA, 1'b0);
        wr_raw(12'hAAA, 8'h77, 8'h00, 4'h0, 1'b0); expect_none("R7 no select");
        wr(12'h554, 8'h55, 1'b0);
        wr(12'hAAA, 8'hC0, 1'b0);
        expect_cmd("R7 sequence survives", E_PROT, 1'b0);
        wr_raw(12'hAAA, 8'hAA, 8'h10, 4'h2, 1'b0);
        wr_raw(12'h554, 8'h55, 8'h01, 4'hF, 1'b0);
        wr_raw(12'hAAA, 8'hB0, 8'h80, 4'h1, 1'b0);
        expect_cmd("R7 primary wins", E_SUSPEND, 1'b0);

        // R9: lockout
        run_cmd(1'b0, 8'hC0, 1'b0, 0, 8'h00, "R9 setup");
        wr_raw(12'hAAA, 8'hB0, rnd_pri(), 4'h0, 1'b1);
        expect_none("R9 locked single");
        chk(mode_pri == 2'd3, "R9 mode kept", int'(mode_pri), 3);
        unlock(1'b0, 0);
        wr_raw(12'hAAA, 8'h90, rnd_pri(), 4'h0, 1'b1);
        expect_none("R9 locked command");
        wr(12'hAAA, 8'hC0, 1'b0);
        expect_cmd("R9 sequence survives", E_PROT, 1'b0);

        // R12: single-byte commands
        wr(12'h123, 8'hB0, 1'b1); expect_cmd("R12 suspend", E_SUSPEND, 1'b1);
        wr(12'h456, 8'h30, 1'b1); expect_cmd("R12 resume", E_RESUME, 1'b1);
        wr(12'h777, 8'hF0, 1'b1); expect_cmd("R12 reset", E_RESET, 1'b1);

        // R10: bypass
        run_cmd(1'b0, 8'h20, 1'b0, 0, 8'h00, "R10 enter");
        run_cmd(1'b0, 8'hA0, 1'b1, 1, 8'h00, "R10 program");
        run_cmd(1'b0, 8'h80, 1'b1, 0, 8'h30, "R10 sector erase");
        run_cmd(1'b0, 8'h80, 1'b1, 2, 8'h10, "R10 chip erase");
        wr(12'hAAA, 8'hA0, 1'b1); expect_none("R10 sec not bypassed");
        wr(12'h100, 8'h12, 1'b1); expect_none("R10 sec no program");
        wr(12'hAAA, 8'hF0, 1'b0); expect_cmd("R10 exit", E_BYP_OFF, 1'b0);
        wr(12'hAAA, 8'hA0, 1'b0); expect_none("R10 bypass cleared");
        wr(12'h200, 8'h34, 1'b0); expect_none("R10 bypass cleared data");

        // R3 R4 R6: random legal sequences
        tmo_limit = 16'd3;
        for (int i = 0; i < 300; i++) begin
            bit b = 1'($urandom);
            logic [7:0] code;
            case ($urandom_range(0, 6))
                0: code = 8'hA0;
                1: code = 8'h80;
                2: code = 8'hF0;
                3: code = 8'hB0;
                4: code = 8'h30;
                5: code = b ? 8'hC0 : 8'h90;
                default: code = 8'hC0;
            endcase
            run_cmd(b, code, 1'b0, $urandom_range(0, 3),
                    $urandom_range(0, 1) ? 8'h10 : 8'h30, "R3 random");
            idle($urandom_range(0, 5));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule